// File: doc/BRIEF.md
# SPI Register Target with Packet Buffer Port

This block is an SPI target that lets a host microcontroller reach a bank of 128 byte-wide registers and a packet buffer. Each chip-select frame opens with one command byte. Its top bit gives the direction and its low seven bits give a register address. Every byte the host clocks after the command writes or reads consecutive locations.

One address is special. Address 0x00 is a window into the packet buffer. Accesses through it follow a separate, host-settable buffer pointer, and the register address stays where it is.

The bank also holds an event-flag register with a companion mask. Pulses on the event inputs latch into the flags. The host clears a flag by writing a 1 to its bit. A routing field selects which flag can drive the interrupt line. All SPI signals are brought into the system clock domain, and the system clock must run at least eight times faster than SCLK.

Top module: `spi_reg_target`

## Requirements
- R1: The first byte of a frame is a command. If bit 7 is 1 the frame writes; if bit 7 is 0 the frame reads. Bits 6:0 give the start address.
- R2: In a read frame the block returns one data byte for every filler byte the host clocks in. SPI runs in mode 0 with the MSB first. The host samples MISO on rising SCLK.
- R3: A frame may carry any number of data bytes. Raising chip-select ends the frame, and the next frame starts again with a command byte.
- R4: Each data byte at address 0x00 writes or reads the buffer entry at the buffer pointer. The pointer then advances by one, and the address stays 0x00.
- R5: The buffer pointer is read and written at address 0x0D. It wraps modulo FIFO_DEPTH. Addresses 0x0E, 0x0F and 0x10 are plain read/write storage.
- R6: The flag register is at 0x12. A pulse on evt_i[k] sets flag bit k, and the flag holds until cleared. Writing 1 to a bit clears it, and writing 0xFF clears every flag. If a set and a clear reach the same bit in the same cycle, the set wins.
- R7: The mask register is at 0x11. A mask bit of 1 keeps its flag from driving irq_o, but the flag still latches. The route field, bits 7:6 of register 0x40, picks the flag that can drive irq_o: 00 selects flag bit 6, 01 selects bit 3, 10 selects bit 2, and 11 selects none. irq_o follows one system clock after its inputs.
- R8: Address 0x42 reads back the VERSION parameter, and writes to it are ignored.
- R9: Bursts at any address other than 0x00 step the address by one per data byte. The address wraps from 0x7F to 0x00.
- R10: After reset all registers read 0, the buffer pointer is 0, and both irq_o and spi_miso_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI serial clock, idle low |
| spi_csn_i | input | 1 | SPI chip-select, active low |
| spi_mosi_i | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial data to the host |
| evt_i | input | 8 | Single-cycle event pulses, one per flag bit |
| irq_o | output | 1 | Routed, unmasked interrupt request |

## Verification
The assertions assume that events arrive as pulses synchronous to the system clock. They also assume that SCLK changes slowly enough for every edge to pass the synchroniser as a separate level, and that chip-select is raised only after a whole byte. The stimulus keeps to these rules: each SCLK half period lasts six system clocks, frames always carry whole bytes, and events are driven for exactly one cycle on the falling clock edge. Random frames use any address and burst length. Every returned byte is predicted by a bench model of the register file, the pointer and the flags.

// File: rtl/spt_pkg.sv
package spt_pkg;

   localparam int unsigned ADDR_W    = 7;
   localparam int unsigned REG_COUNT = 2 ** ADDR_W;

   typedef logic [7:0]        byte_t;
   typedef logic [ADDR_W-1:0] raddr_t;

   localparam raddr_t ADR_FIFO   = 7'h00;
   localparam raddr_t ADR_PTR    = 7'h0D;
   localparam raddr_t ADR_MASK   = 7'h11;
   localparam raddr_t ADR_FLAGS  = 7'h12;
   localparam raddr_t ADR_ROUTE  = 7'h40;
   localparam raddr_t ADR_VER    = 7'h42;

   localparam int unsigned FLG_RX_DONE  = 6;
   localparam int unsigned FLG_TX_DONE  = 3;
   localparam int unsigned FLG_CAD_DONE = 2;

   typedef enum logic [1:0] {
      RT_RX_DONE  = 2'b00,
      RT_TX_DONE  = 2'b01,
      RT_CAD_DONE = 2'b10,
      RT_OFF      = 2'b11
   } route_e;

   function automatic byte_t route_vector(route_e r);
      byte_t v;
      v = '0;
      case (r)
         RT_RX_DONE:  v[FLG_RX_DONE]  = 1'b1;
         RT_TX_DONE:  v[FLG_TX_DONE]  = 1'b1;
         RT_CAD_DONE: v[FLG_CAD_DONE] = 1'b1;
         default:     v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/spt_spi_shifter.sv
module spt_spi_shifter
   import spt_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sclk_i,
   input  logic  csn_i,
   input  logic  mosi_i,
   input  logic  resp_stb_i,
   input  byte_t resp_data_i,
   output logic  miso_o,
   output logic  sel_o,
   output logic  byte_stb_o,
   output byte_t byte_o
);

   localparam int BIT_W = $clog2($bits(byte_t));
   localparam logic [2:0] SYNC_RST = 3'b010;

   logic [2:0] sync_q [SYNC_STAGES];
   logic       sclk_s, csn_s, mosi_s, sclk_d;
   logic       rise, fall;
   logic [BIT_W-1:0] bit_cnt_q;
   logic [6:0] rx_sr_q;
   logic [6:0] tx_sr_q;
   logic       miso_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= SYNC_RST;
      end else begin
         sync_q[0] <= {sclk_i, csn_i, mosi_i};
         for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      end
   end

   assign sclk_s = sync_q[SYNC_STAGES-1][2];
   assign csn_s  = sync_q[SYNC_STAGES-1][1];
   assign mosi_s = sync_q[SYNC_STAGES-1][0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign sel_o = ~csn_s;
   assign rise  = sel_o & sclk_s & ~sclk_d;
   assign fall  = sel_o & ~sclk_s & sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_q <= '0;
         rx_sr_q   <= '0;
      end else if (!sel_o) begin
         bit_cnt_q <= '0;
      end else if (rise) begin
         rx_sr_q   <= {rx_sr_q[5:0], mosi_s};
         bit_cnt_q <= bit_cnt_q + 1'b1;
      end
   end

   assign byte_stb_o = rise && (bit_cnt_q == BIT_W'(7));
   assign byte_o     = {rx_sr_q, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miso_q  <= 1'b0;
         tx_sr_q <= '0;
      end else if (!sel_o) begin
         miso_q  <= 1'b0;
      end else if (resp_stb_i) begin
         miso_q  <= resp_data_i[7];
         tx_sr_q <= resp_data_i[6:0];
      end else if (fall && (bit_cnt_q != '0)) begin
         miso_q  <= tx_sr_q[6];
         tx_sr_q <= {tx_sr_q[5:0], 1'b0};
      end
   end

   assign miso_o = miso_q;

endmodule

// File: rtl/spt_irq_ctrl.sv
module spt_irq_ctrl
   import spt_pkg::*;
#(
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  byte_t  evt_i,
   input  logic   clr_stb_i,
   input  byte_t  clr_bits_i,
   input  byte_t  mask_i,
   input  route_e route_i,
   output byte_t  flags_o,
   output logic   irq_o
);

   byte_t flags_q;
   byte_t clr_vec;
   logic  irq_raw;

   assign clr_vec = clr_stb_i ? clr_bits_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_vec) | evt_i;
   end

   assign flags_o = flags_q;
   assign irq_raw = |(flags_q & ~mask_i & route_vector(route_i));

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_raw;
      end
   endgenerate

endmodule

// File: rtl/spt_regbank.sv
module spt_regbank
   import spt_pkg::*;
#(
   parameter int    FIFO_DEPTH     = 256,
   parameter byte_t VERSION        = 8'h31,
   parameter bit    IRQ_REGISTERED = 1'b1,
   localparam int   PTR_W          = $clog2(FIFO_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic             byte_stb_i,
   input  byte_t            byte_i,
   input  byte_t            evt_i,
   output logic             resp_stb_o,
   output byte_t            resp_data_o,
   output logic             irq_o,
   output logic             cmd_phase_o,
   output raddr_t           cur_addr_o,
   output logic [PTR_W-1:0] fifo_ptr_o,
   output byte_t            flags_o,
   output byte_t            mask_o
);

   logic             cmd_phase_q;
   logic             wr_frame_q;
   raddr_t           addr_q;
   logic [PTR_W-1:0] ptr_q;
   byte_t            regs_q [REG_COUNT];
   byte_t            ram_q  [FIFO_DEPTH];
   logic             resp_stb_q;
   byte_t            resp_data_q;

   raddr_t           look_addr;
   logic [PTR_W-1:0] look_ptr;
   byte_t            look_data;
   logic             data_stb, wr_stb, rd_stb, on_fifo;
   byte_t            flags;

   assign data_stb = sel_i & byte_stb_i & ~cmd_phase_q;
   assign wr_stb   = data_stb & wr_frame_q;
   assign rd_stb   = data_stb & ~wr_frame_q;
   assign on_fifo  = (addr_q == ADR_FIFO);

   // location whose content goes out with the next byte on MISO
   always_comb begin
      if (cmd_phase_q) begin
         look_addr = byte_i[ADDR_W-1:0];
         look_ptr  = ptr_q;
      end else if (on_fifo) begin
         look_addr = ADR_FIFO;
         look_ptr  = ptr_q + 1'b1;
      end else begin
         look_addr = addr_q + 1'b1;
         look_ptr  = ptr_q;
      end
      case (look_addr)
         ADR_FIFO:  look_data = ram_q[look_ptr];
         ADR_PTR:   look_data = byte_t'(ptr_q);
         ADR_FLAGS: look_data = flags;
         ADR_VER:   look_data = VERSION;
         default:   look_data = regs_q[look_addr];
      endcase
   end

   // frame sequencing, address and pointer stepping
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_phase_q <= 1'b1;
         wr_frame_q  <= 1'b0;
         addr_q      <= '0;
         ptr_q       <= '0;
         resp_stb_q  <= 1'b0;
         resp_data_q <= '0;
      end else begin
         resp_stb_q <= 1'b0;
         if (!sel_i) begin
            cmd_phase_q <= 1'b1;
         end else if (byte_stb_i && cmd_phase_q) begin
            cmd_phase_q <= 1'b0;
            wr_frame_q  <= byte_i[7];
            addr_q      <= byte_i[ADDR_W-1:0];
            resp_stb_q  <= ~byte_i[7];
            resp_data_q <= look_data;
         end else if (data_stb) begin
            if (rd_stb) begin
               resp_stb_q  <= 1'b1;
               resp_data_q <= look_data;
            end
            if (on_fifo) begin
               ptr_q <= ptr_q + 1'b1;
            end else begin
               addr_q <= addr_q + 1'b1;
               if (wr_stb && (addr_q == ADR_PTR)) ptr_q <= byte_i[PTR_W-1:0];
            end
         end
      end
   end

   // plain storage registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= '0;
      end else if (wr_stb) begin
         if ((addr_q != ADR_FIFO) && (addr_q != ADR_PTR) &&
             (addr_q != ADR_FLAGS) && (addr_q != ADR_VER)) begin
            regs_q[addr_q] <= byte_i;
         end
      end
   end

   // packet buffer
   always_ff @(posedge clk) begin
      if (wr_stb && on_fifo) ram_q[ptr_q] <= byte_i;
   end

   spt_irq_ctrl #(
      .IRQ_REGISTERED (IRQ_REGISTERED)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .clr_stb_i  (wr_stb && (addr_q == ADR_FLAGS)),
      .clr_bits_i (byte_i),
      .mask_i     (regs_q[ADR_MASK]),
      .route_i    (route_e'(regs_q[ADR_ROUTE][7:6])),
      .flags_o    (flags),
      .irq_o      (irq_o)
   );

   assign resp_stb_o  = resp_stb_q;
   assign resp_data_o = resp_data_q;
   assign cmd_phase_o = cmd_phase_q;
   assign cur_addr_o  = addr_q;
   assign fifo_ptr_o  = ptr_q;
   assign flags_o     = flags;
   assign mask_o      = regs_q[ADR_MASK];

endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
   import spt_pkg::*;
#(
   parameter int    FIFO_DEPTH     = 256,
   parameter int    SYNC_STAGES    = 2,
   parameter byte_t VERSION        = 8'h31,
   parameter bit    IRQ_REGISTERED = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sclk_i,
   input  logic       spi_csn_i,
   input  logic       spi_mosi_i,
   output logic       spi_miso_o,
   input  logic [7:0] evt_i,
   output logic       irq_o
);

   localparam int PTR_W = $clog2(FIFO_DEPTH);

   generate
      if ((FIFO_DEPTH < 2) || (FIFO_DEPTH > 256) || ((1 << PTR_W) != FIFO_DEPTH)) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two from 2 to 256");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             sel;
   logic             byte_stb;
   byte_t            byte_rx;
   logic             resp_stb;
   byte_t            resp_data;
   logic             cmd_phase;
   raddr_t           cur_addr;
   logic [PTR_W-1:0] fifo_ptr;
   byte_t            flags;
   byte_t            mask;

   spt_spi_shifter #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_i      (spi_sclk_i),
      .csn_i       (spi_csn_i),
      .mosi_i      (spi_mosi_i),
      .resp_stb_i  (resp_stb),
      .resp_data_i (resp_data),
      .miso_o      (spi_miso_o),
      .sel_o       (sel),
      .byte_stb_o  (byte_stb),
      .byte_o      (byte_rx)
   );

   spt_regbank #(
      .FIFO_DEPTH     (FIFO_DEPTH),
      .VERSION        (VERSION),
      .IRQ_REGISTERED (IRQ_REGISTERED)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_i       (sel),
      .byte_stb_i  (byte_stb),
      .byte_i      (byte_rx),
      .evt_i       (evt_i),
      .resp_stb_o  (resp_stb),
      .resp_data_o (resp_data),
      .irq_o       (irq_o),
      .cmd_phase_o (cmd_phase),
      .cur_addr_o  (cur_addr),
      .fifo_ptr_o  (fifo_ptr),
      .flags_o     (flags),
      .mask_o      (mask)
   );

endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
   parameter int PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_stb,
   input logic             cmd_phase,
   input logic [6:0]       cur_addr,
   input logic [PTR_W-1:0] fifo_ptr,
   input logic [7:0]       flags,
   input logic [7:0]       mask,
   input logic [7:0]       evt,
   input logic             irq
);

   assert_fifo_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && !cmd_phase && cur_addr == 7'h00) |=> fifo_ptr == $past(fifo_ptr) + 1'b1);

   assert_fifo_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && !cmd_phase && cur_addr == 7'h00) |=> cur_addr == 7'h00);

   assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && !cmd_phase && cur_addr != 7'h00) |=> cur_addr == $past(cur_addr) + 7'd1);

   assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt == 8'h00 && !byte_stb) |=> $stable(flags));

   assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != 8'h00) |=> ((flags & $past(evt)) == $past(evt)));

   assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == 8'hFF && $past(mask) == 8'hFF) |-> !irq);

endmodule

bind spi_reg_target spt_checker #(.PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .byte_stb  (byte_stb),
   .cmd_phase (cmd_phase),
   .cur_addr  (cur_addr),
   .fifo_ptr  (fifo_ptr),
   .flags     (flags),
   .mask      (mask),
   .evt       (evt_i),
   .irq       (irq_o)
);

// File: tb/tb_spi_reg_target.sv
module tb_spi_reg_target;
   import spt_pkg::*;

   localparam int    CLK_PERIOD = 10;
   localparam int    HALF       = 6;
   localparam byte_t VER        = 8'h31;
   localparam int    WD_LIMIT   = 190000;

   logic  clk = 1'b0, rst_n = 1'b0;
   logic  sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
   logic  miso, irq;
   byte_t evt = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_reg_target #(.VERSION(VER)) dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_csn_i(csn),
      .spi_mosi_i(mosi), .spi_miso_o(miso), .evt_i(evt), .irq_o(irq));

   int    n_checks = 0, n_fail = 0, cyc = 0;
   byte_t m_regs [128];
   byte_t m_ram  [256];
   byte_t m_ptr, m_flags;
   byte_t txb [260];
   byte_t rxb [260];

   task automatic check_eq(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic ticks(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(byte_t tx, output byte_t rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         ticks(HALF);
         sclk = 1'b1;
         rx[i] = miso;
         ticks(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic frame(bit wr, raddr_t a, int n);
      byte_t dummy;
      csn = 1'b0;
      ticks(HALF);
      xfer({wr, a}, dummy);
      for (int i = 0; i < n; i++) xfer(wr ? txb[i] : 8'h00, rxb[i]);
      ticks(HALF);
      csn = 1'b1;
      ticks(4*HALF);
   endtask

   function automatic byte_t m_rd(raddr_t a);
      case (a)
         7'h00:   return m_ram[m_ptr];
         7'h0D:   return m_ptr;
         7'h12:   return m_flags;
         7'h42:   return VER;
         default: return m_regs[a];
      endcase
   endfunction

   task automatic m_wr(raddr_t a, byte_t d);
      case (a)
         7'h00:   m_ram[m_ptr] = d;
         7'h0D:   m_ptr = d;
         7'h12:   m_flags = m_flags & ~d;
         7'h42:   ;
         default: m_regs[a] = d;
      endcase
   endtask

   task automatic do_write(raddr_t a, int n);
      raddr_t c = a;
      frame(1'b1, a, n);
      for (int i = 0; i < n; i++) begin
         m_wr(c, txb[i]);
         if (c == 7'h00) m_ptr = m_ptr + 8'd1;
         else            c = c + 7'd1;
      end
   endtask

   task automatic do_read(raddr_t a, int n, string tag);
      raddr_t c = a;
      frame(1'b0, a, n);
      for (int i = 0; i < n; i++) begin
         check_eq(tag, rxb[i], m_rd(c));
         if (c == 7'h00) m_ptr = m_ptr + 8'd1;
         else            c = c + 7'd1;
      end
   endtask

   task automatic wr1(raddr_t a, byte_t d);
      txb[0] = d;
      do_write(a, 1);
   endtask

   function automatic bit m_irq();
      return |(m_flags & ~m_regs[7'h11] & route_vector(route_e'(m_regs[7'h40][7:6])));
   endfunction

   task automatic pulse(byte_t v);
      @(negedge clk) evt = v;
      @(negedge clk) evt = '0;
      m_flags = m_flags | v;
      ticks(3);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog R3 actual=%0d expected<%0d", cyc, WD_LIMIT);
         finish_run();
      end
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd4711);
      for (int i = 0; i < 128; i++) m_regs[i] = '0;
      for (int i = 0; i < 256; i++) m_ram[i] = '0;
      m_ptr = '0;
      m_flags = '0;
      ticks(5);
      rst_n = 1'b1;
      ticks(3);

      // R10: reset state
      check_eq("R10 irq after reset", irq, 0);
      check_eq("R10 miso after reset", miso, 0);
      do_read(7'h0D, 4, "R10 pointer and base registers after reset");
      do_read(7'h11, 2, "R10 mask and flags after reset");

      // R8: fixed version, write ignored
      do_read(7'h42, 1, "R8 version read");
      wr1(7'h42, 8'hC3);
      do_read(7'h42, 1, "R8 version after write");

      // R4 R5: fill the whole buffer, pointer wraps back to 0
      wr1(7'h0D, 8'h00);
      for (int i = 0; i < 256; i++) txb[i] = byte_t'(i) ^ 8'hA5;
      do_write(7'h00, 256);
      do_read(7'h0D, 1, "R5 pointer wrap after full buffer");
      wr1(7'h0D, 8'h10);
      do_read(7'h00, 5, "R4 buffer burst read");
      do_read(7'h0D, 1, "R5 pointer after five reads");
      do_read(7'h0E, 3, "R5 base registers");

      // R1 R2 R3 R9: register burst, new command per frame
      txb[0] = 8'h12; txb[1] = 8'h34; txb[2] = 8'h56; txb[3] = 8'h78;
      do_write(7'h20, 4);
      do_read(7'h20, 4, "R1 R2 R3 R9 burst read back");
      do_read(7'h22, 1, "R3 fresh command after chip-select");

      // R9: wrap from 0x7F into the buffer port
      txb[0] = 8'hE1; txb[1] = 8'hE2; txb[2] = 8'hE3;
      do_write(7'h7E, 3);
      do_read(7'h0D, 1, "R9 pointer after wrap write");
      wr1(7'h0D, m_ptr - 8'd1);
      do_read(7'h7E, 3, "R9 wrap read");

      // R6 R7: flags, mask, routing
      pulse(8'h48);
      do_read(7'h12, 1, "R6 flags latched");
      check_eq("R7 irq rx-done routed", irq, m_irq());
      check_eq("R7 irq rx-done expected high", int'(m_irq()), 1);
      wr1(7'h12, 8'h40);
      do_read(7'h12, 1, "R6 write one clears bit");
      check_eq("R7 irq after clear", irq, m_irq());
      wr1(7'h40, 8'h40);
      check_eq("R7 irq tx-done route", irq, 1);
      wr1(7'h11, 8'h08);
      check_eq("R7 masked flag keeps irq low", irq, 0);
      do_read(7'h12, 1, "R7 masked flag still latched");
      wr1(7'h12, 8'hFF);
      do_read(7'h12, 1, "R6 write all ones clears");
      pulse(8'h04);
      wr1(7'h40, 8'h80);
      check_eq("R7 irq cad-done route", irq, 1);
      wr1(7'h40, 8'hC0);
      check_eq("R7 irq route off", irq, 0);
      pulse(8'h81);
      do_read(7'h12, 1, "R6 further flags");

      // random frames over the whole address space
      for (int k = 0; k < 40; k++) begin
         bit     wr;
         raddr_t a;
         int     n;
         wr = 1'($urandom % 2);
         a  = raddr_t'($urandom % 128);
         n  = 1 + int'($urandom % 4);
         if (wr) begin
            for (int i = 0; i < n; i++) txb[i] = byte_t'($urandom);
            do_write(a, n);
         end else begin
            do_read(a, n, "R1/R9 random read");
         end
         check_eq("R7 irq after random frame", irq, m_irq());
      end

      finish_run();
   end

endmodule